// File: doc/BRIEF.md
# Balanced Ternary Two-Trit Calculator

This block is a purely combinational arithmetic unit that works in balanced ternary. Each digit (trit) takes the value -1, 0 or +1 and travels as a 2-bit binary code. Two operands, X and Y, each two trits wide, arrive packed on one 8-bit input bus. A 4-trit result leaves on an 8-bit output bus.

The unit has two functions. It can multiply, or it can add. Subtraction needs no separate function, because in balanced ternary a negative operand is written directly and no complement step is needed. The most significant trit of X also selects the function. A value of -1 there means multiply. A value of 0 or +1 means add. Because of this, each function can only see part of the X operand range.

No clock, register or reset is involved. The output depends only on the present input bus.

Top module: `bt_calc`

## Requirements
- R1: Each trit is coded as -1 = 2'b01, 0 = 2'b11 and +1 = 2'b10. An all-zero-value input (8'hFF) gives an all-zero-value output (8'hFF).
- R2: The input bus packs x1 in bits [7:6], x0 in [5:4], y1 in [3:2] and y0 in [1:0], with weights 3 and 1 within each operand. In each pair, the higher bit is the code's MSB.
- R3: The output bus packs s3 in bits [7:6], s2 in [5:4], s1 in [3:2] and s0 in [1:0], with positional weights 27, 9, 3 and 1.
- R4: When x1 carries the code for -1 (2'b01), the output is the exact balanced ternary value of X*Y.
- R5: When x1 carries 0 or +1, the output is the exact balanced ternary value of X+Y. A negative Y therefore performs subtraction.
- R6: The output never carries the unused code 2'b00 in any trit position, for every one of the 256 input patterns.
- R7: An input trit holding 2'b00 counts as 0, both as an operand value and, in x1, as the function select. A 2'b00 in x1 therefore selects add.
- R8: X = -4 (trits -1,-1) times Y = -4 gives +16, shown on the bus as 8'b10010110.
- R9: The output follows a change of the input without any clock edge.
- R10: In add mode, the top result trit s3 is always 0 (2'b11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opIn | input | 8 | Packed operand trits x1, x0, y1, y0; x1 also selects the function |
| resOut | output | 8 | Packed result trits s3, s2, s1, s0 |

## Verification
The hardest cases to reach are the ones where one input bit pair does two jobs or holds a code with no meaning. An x1 of 2'b00 must pick add and also count as zero weight. Illegal codes in the other positions must still produce a legal, correct result. The stimulus sweeps all 256 bit patterns, not just the 81 legal trit combinations, so every mix of illegal codes with both functions is covered. The expected value comes from the bench's own decoding of each pattern. The negative extremes, where both operands are -4, and the positive add extreme of 4+4 are reached inside that sweep and are also driven as directed vectors.

// File: rtl/bt_pkg.sv
package bt_pkg;

  // Binary codes carried on the buses for each trit value
  typedef enum logic [1:0] {
    TRIT_NEG  = 2'b01,
    TRIT_POS  = 2'b10,
    TRIT_ZERO = 2'b11
  } tritCode_e;

  // Strobes from the function selector to the datapath
  typedef struct packed {
    logic doMul;
    logic doAdd;
  } opStrobe_t;

  // Value of one coded trit; the unused code reads as zero
  function automatic int tritToInt(input logic [1:0] code);
    case (code)
      TRIT_NEG: return -1;
      TRIT_POS: return 1;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
(
  input  logic [1:0] selCode,
  output opStrobe_t  strobes
);

  // Only a clean -1 code selects multiply; 0, +1 and the unused code add
  always_comb begin
    strobes.doMul = (selCode == TRIT_NEG);
    strobes.doAdd = (selCode != TRIT_NEG);
  end

endmodule

// File: rtl/bt_dec.sv
module bt_dec
  import bt_pkg::*;
#(
  parameter int NTRITS = 2,
  parameter int VAL_W  = 10
) (
  input  logic [2*NTRITS-1:0]     codes,
  output logic signed [VAL_W-1:0] value
);

  int acc;

  // Horner evaluation from the most significant trit down
  always_comb begin
    acc = 0;
    for (int i = NTRITS - 1; i >= 0; i--) begin
      acc = acc * 3 + tritToInt(codes[2*i +: 2]);
    end
    value = VAL_W'(acc);
  end

endmodule

// File: rtl/bt_enc.sv
module bt_enc
  import bt_pkg::*;
#(
  parameter int NTRITS = 4,
  parameter int VAL_W  = 10
) (
  input  logic signed [VAL_W-1:0] value,
  output logic [2*NTRITS-1:0]     codes
);

  int rest;
  int modThree;

  // Peel off balanced digits from the least significant end
  always_comb begin
    rest = int'(value);
    codes = '1;
    for (int i = 0; i < NTRITS; i++) begin
      modThree = ((rest % 3) + 3) % 3;
      case (modThree)
        1: begin
          codes[2*i +: 2] = TRIT_POS;
          rest = (rest - 1) / 3;
        end
        2: begin
          codes[2*i +: 2] = TRIT_NEG;
          rest = (rest + 1) / 3;
        end
        default: begin
          codes[2*i +: 2] = TRIT_ZERO;
          rest = rest / 3;
        end
      endcase
    end
  end

endmodule

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int OP_TRITS  = 2,
  parameter int RES_TRITS = 4
) (
  input  logic [4*OP_TRITS-1:0]  opIn,
  input  opStrobe_t              strobes,
  output logic [2*RES_TRITS-1:0] resOut
);

  localparam int OP_BITS = 2 * OP_TRITS;
  localparam int VAL_W   = 2 * RES_TRITS + 2;

  logic signed [VAL_W-1:0] xVal;
  logic signed [VAL_W-1:0] yVal;
  logic signed [VAL_W-1:0] resVal;

  bt_dec #(.NTRITS(OP_TRITS), .VAL_W(VAL_W)) u_decX (
    .codes (opIn[2*OP_BITS-1 -: OP_BITS]),
    .value (xVal)
  );

  bt_dec #(.NTRITS(OP_TRITS), .VAL_W(VAL_W)) u_decY (
    .codes (opIn[OP_BITS-1:0]),
    .value (yVal)
  );

  always_comb begin
    if (strobes.doMul)      resVal = VAL_W'(int'(xVal) * int'(yVal));
    else if (strobes.doAdd) resVal = xVal + yVal;
    else                    resVal = '0;
  end

  bt_enc #(.NTRITS(RES_TRITS), .VAL_W(VAL_W)) u_enc (
    .value (resVal),
    .codes (resOut)
  );

endmodule

// File: rtl/bt_calc.sv
module bt_calc
  import bt_pkg::*;
#(
  parameter int OP_TRITS  = 2,
  parameter int RES_TRITS = 4
) (
  input  logic [4*OP_TRITS-1:0]  opIn,
  output logic [2*RES_TRITS-1:0] resOut
);

  localparam int IN_W = 4 * OP_TRITS;

  opStrobe_t strobes;

  bt_ctrl u_ctrl (
    .selCode (opIn[IN_W-1 -: 2]),
    .strobes (strobes)
  );

  bt_datapath #(.OP_TRITS(OP_TRITS), .RES_TRITS(RES_TRITS)) u_dp (
    .opIn    (opIn),
    .strobes (strobes),
    .resOut  (resOut)
  );

endmodule

// File: rtl/bt_calc_chk.sv
module bt_calc_chk #(
  parameter int OP_TRITS  = 2,
  parameter int RES_TRITS = 4
) (
  input logic [4*OP_TRITS-1:0]  opIn,
  input logic [2*RES_TRITS-1:0] resOut,
  input logic                   mulStrobe
);

  int xv, yv, sv;
  logic anyIllegal;

  function automatic int codeVal(input logic [1:0] c);
    if (c == 2'b10) return 1;
    if (c == 2'b01) return -1;
    return 0;
  endfunction

  always_comb begin
    xv = 0; yv = 0; sv = 0; anyIllegal = 1'b0;
    for (int i = 2 * OP_TRITS - 1; i >= OP_TRITS; i--) xv = xv * 3 + codeVal(opIn[2*i +: 2]);
    for (int i = OP_TRITS - 1; i >= 0; i--)            yv = yv * 3 + codeVal(opIn[2*i +: 2]);
    for (int i = RES_TRITS - 1; i >= 0; i--) begin
      sv = sv * 3 + codeVal(resOut[2*i +: 2]);
      if (resOut[2*i +: 2] == 2'b00) anyIllegal = 1'b1;
    end
  end

  always_comb begin
    p_legal_out_r6: assert (!anyIllegal)
      else $error("result trit uses the unused code");
    // R4 and R7: product, with unused input codes counted as zero
    p_mul_exact_r4: assert (!mulStrobe || sv == xv * yv)
      else $error("product mismatch");
    // R5 and R7: sum when the select is not -1
    p_add_exact_r5: assert (mulStrobe || sv == xv + yv)
      else $error("sum mismatch");
    p_add_top_zero_r10: assert (mulStrobe || resOut[2*RES_TRITS-1 -: 2] == 2'b11)
      else $error("top trit nonzero in add mode");
    p_neg4_square_r8: assert (opIn != 8'h55 || resOut == 8'h96)
      else $error("-4 * -4 not 16");
  end

endmodule

bind bt_calc bt_calc_chk #(.OP_TRITS(OP_TRITS), .RES_TRITS(RES_TRITS)) u_chk (
  .opIn      (opIn),
  .resOut    (resOut),
  .mulStrobe (strobes.doMul)
);

// File: tb/bt_calc_bench.sv
module bt_calc_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] opIn = 8'hFF;
  logic [7:0] resOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] itemQ[$];
  string tagQ[$];

  bt_calc u_bt_calc (.opIn(opIn), .resOut(resOut));

  function automatic int bDec(input logic [1:0] c);
    case (c)
      2'b10:   return 1;
      2'b01:   return -1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] bEnc(input int v);
    logic [7:0] r;
    int rem;
    r = 8'hFF;
    rem = v;
    for (int i = 0; i < 4; i++) begin
      int d;
      d = 0;
      if (((rem - 1) % 3) == 0) d = 1;
      else if (((rem + 1) % 3) == 0) d = -1;
      r[2*i +: 2] = (d == 1) ? 2'b10 : (d == -1) ? 2'b01 : 2'b11;
      rem = (rem - d) / 3;
    end
    return r;
  endfunction

  task automatic pushItem(input logic [7:0] stim, input logic [7:0] expv, input string tag);
    @(posedge clk);
    #1;
    opIn = stim;
    itemQ.push_back({stim, expv});
    tagQ.push_back(tag);
  endtask

  // Monitor: compare at the falling edge, away from the driver
  initial begin
    forever begin
      @(negedge clk);
      if (itemQ.size() > 0) begin
        logic [15:0] it;
        string tag;
        it = itemQ.pop_front();
        tag = tagQ.pop_front();
        checks++;
        if (resOut !== it[7:0]) begin
          errors++;
          $display("FAIL %s stim=%h got=%h exp=%h", tag, it[15:8], resOut, it[7:0]);
        end
        // R6: every result trit legal
        checks++;
        if (resOut[7:6] == 2'b00 || resOut[5:4] == 2'b00 ||
            resOut[3:2] == 2'b00 || resOut[1:0] == 2'b00) begin
          errors++;
          $display("FAIL R6 stim=%h got=%h exp=no 00 trit", it[15:8], resOut);
        end
        // R10: add mode keeps s3 at zero
        if (it[15:14] != 2'b01) begin
          checks++;
          if (resOut[7:6] != 2'b11) begin
            errors++;
            $display("FAIL R10 stim=%h got=%b exp=11", it[15:8], resOut[7:6]);
          end
        end
      end
    end
  end

  initial begin
    #2;
    checks++;
    if (resOut !== 8'hFF) begin
      errors++;
      $display("FAIL R1 got=%h exp=ff", resOut);
    end
    // R9: no clock edge between drive and sample
    @(negedge clk);
    opIn = 8'h55;
    #1;
    checks++;
    if (resOut !== 8'h96) begin
      errors++;
      $display("FAIL R9 got=%h exp=96", resOut);
    end

    pushItem(8'hFF, 8'hFF, "R1");
    pushItem(8'hBF, 8'hFB, "R2");   // X=+3, Y=0, add
    pushItem(8'h7A, 8'hD7, "R3");   // X=-3, Y=+4, multiply -> -12
    pushItem(8'h55, 8'h96, "R8");
    pushItem(8'hAA, bEnc(8), "R5"); // 4 + 4
    pushItem(8'h3D, bEnc(-1), "R7"); // x1 unused code -> add, 0+(-1)

    for (int a = 0; a < 256; a++) begin
      logic [7:0] s;
      int x, y, ev;
      string tag;
      s = 8'(a);
      x = 3 * bDec(s[7:6]) + bDec(s[5:4]);
      y = 3 * bDec(s[3:2]) + bDec(s[1:0]);
      ev = (s[7:6] == 2'b01) ? x * y : x + y;
      if (s[7:6] == 2'b00 || s[5:4] == 2'b00 || s[3:2] == 2'b00 || s[1:0] == 2'b00)
        tag = "R7";
      else if (s[7:6] == 2'b01)
        tag = "R4";
      else
        tag = "R5";
      pushItem(s, bEnc(ev), tag);
    end

    while (itemQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule